// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the general registers of a 32-bit processor core whose register view changes with the processor mode. The instruction stream addresses sixteen architectural registers through a 4-bit index. A 5-bit mode code from the core decides which physical word each index reaches. Index 13 is the stack pointer, index 14 is the link register and index 15 is the program counter. The program counter is not stored here: reads of index 15 return a value the fetch logic supplies, and writes to index 15 come out as a branch request.

The file has two combinational read ports and one write port, and the write commits on the rising clock edge. Registers 0 to 7 are the same word in every mode. Fast-interrupt mode has its own copies of registers 8 to 12. Each of the five exception modes has its own stack pointer and link register, and user and system mode share one pair between them. The physical store is thirty words.

Next to the general registers sits a bank of saved-status words, one for each exception mode. The bank has its own combinational read port and its own write port, and the current mode selects the word.

Top module: `banked_regfile`

## Requirements
- R1: Indices 0 to 7 reach the same physical register in every mode, including unlisted mode codes.
- R2: Indices 8 to 12 reach a private set of registers in fast-interrupt mode (code 5'h11). Every other mode shares a second set.
- R3: Indices 13 and 14 reach a private pair in each of supervisor (5'h13), abort (5'h17), undefined (5'h1B), interrupt (5'h12) and fast-interrupt (5'h11) mode. User (5'h10), system (5'h1F) and any unlisted code share one pair.
- R4: A read of index 15 on either read port returns `pc_i`.
- R5: A write to index 15 raises `branch_valid_o` in the same cycle, with `branch_target_o` equal to the write data. It changes no stored register.
- R6: A read of the physical register being written in the same cycle returns the old value. The new value is readable from the next cycle.
- R7: Each exception mode has its own saved-status word. `sr_we_i` writes that word at the clock edge, and `sr_rdata_o` shows the word of the current mode.
- R8: In user, system or an unlisted mode, `sr_rdata_o` reads zero and `sr_we_i` changes no saved-status word.
- R9: After reset, every general register and every saved-status word reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_i | input | 5 | Current processor mode code |
| ra_idx_i | input | 4 | Read port A architectural index |
| ra_data_o | output | DATA_W | Read port A data |
| rb_idx_i | input | 4 | Read port B architectural index |
| rb_data_o | output | DATA_W | Read port B data |
| we_i | input | 1 | Write enable for the general registers |
| wa_idx_i | input | 4 | Write architectural index |
| wdata_i | input | DATA_W | Write data |
| pc_i | input | DATA_W | Program-counter value returned for index 15 |
| branch_valid_o | output | 1 | A write addressed index 15 in this cycle |
| branch_target_o | output | DATA_W | Data of that write |
| sr_we_i | input | 1 | Saved-status write enable |
| sr_wdata_i | input | SR_W | Saved-status write data |
| sr_rdata_o | output | SR_W | Saved-status word of the current mode |

## Verification
Two functions can meet in one cycle: a read port and the write port can address the same physical register, and a write to index 15 can coincide with reads of the stored registers. The bench sets both read indices to the register being written. It samples the read data before the clock edge, where the old word is expected, and again after the edge, where the new word is expected. For the branch case it checks the branch outputs while the write is driven. It then reads back the whole view of that mode, which must be unchanged. All expected read data come from a bench rule that finds, for each mode and index, the most recent writer whose register is shared under R1 to R3.

// File: rtl/banked_rf_pkg.sv
package banked_rf_pkg;

  localparam int MODE_W   = 5;
  localparam int IDX_W    = 4;
  localparam int SHARED_N = 8;   // never-banked low registers
  localparam int HIGH_N   = 5;   // registers 8..12
  localparam int EXC_N    = 5;   // modes with own stack/link/status
  localparam int SP_IDX   = 13;
  localparam int PC_IDX   = 15;

  localparam int FIQ_HI_BASE = SHARED_N + HIGH_N;
  localparam int BANK_BASE   = SHARED_N + 2 * HIGH_N;
  localparam int PHYS_N      = BANK_BASE + 2 * (EXC_N + 1);
  localparam int PHYS_AW     = $clog2(PHYS_N);
  localparam int SLOT_W      = $clog2(EXC_N + 1);

  typedef enum logic [MODE_W-1:0] {
    MODE_USR = 5'h10,
    MODE_FIQ = 5'h11,
    MODE_IRQ = 5'h12,
    MODE_SVC = 5'h13,
    MODE_ABT = 5'h17,
    MODE_UND = 5'h1B,
    MODE_SYS = 5'h1F
  } cpu_mode_e;

  localparam logic [SLOT_W-1:0] SLOT_NONE = SLOT_W'(0);
  localparam logic [SLOT_W-1:0] SLOT_SVC  = SLOT_W'(1);
  localparam logic [SLOT_W-1:0] SLOT_ABT  = SLOT_W'(2);
  localparam logic [SLOT_W-1:0] SLOT_UND  = SLOT_W'(3);
  localparam logic [SLOT_W-1:0] SLOT_IRQ  = SLOT_W'(4);
  localparam logic [SLOT_W-1:0] SLOT_FIQ  = SLOT_W'(5);

  // Bank slot of a mode; user, system and unlisted codes share slot 0.
  function automatic logic [SLOT_W-1:0] bank_slot(input logic [MODE_W-1:0] m);
    case (m)
      MODE_SVC: bank_slot = SLOT_SVC;
      MODE_ABT: bank_slot = SLOT_ABT;
      MODE_UND: bank_slot = SLOT_UND;
      MODE_IRQ: bank_slot = SLOT_IRQ;
      MODE_FIQ: bank_slot = SLOT_FIQ;
      default:  bank_slot = SLOT_NONE;
    endcase
  endfunction

endpackage

// File: rtl/rf_rst_sync.sv
module rf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/rf_bank_map.sv
module rf_bank_map
  import banked_rf_pkg::*;
(
  input  logic [MODE_W-1:0]  mode_i,
  input  logic [IDX_W-1:0]   idx_i,
  output logic [PHYS_AW-1:0] phys_o,
  output logic               pc_sel_o
);
  logic [SLOT_W-1:0] slot;
  int unsigned       idx_n;

  assign slot  = bank_slot(mode_i);
  assign idx_n = int'(idx_i);

  always_comb begin
    phys_o   = '0;
    pc_sel_o = 1'b0;
    if (idx_n < SHARED_N) begin
      phys_o = PHYS_AW'(idx_n);
    end else if (idx_n < SHARED_N + HIGH_N) begin
      if (slot == SLOT_FIQ) phys_o = PHYS_AW'(FIQ_HI_BASE + idx_n - SHARED_N);
      else                  phys_o = PHYS_AW'(idx_n);
    end else if (idx_n == PC_IDX) begin
      pc_sel_o = 1'b1;
    end else begin
      phys_o = PHYS_AW'(BANK_BASE + 2 * int'(slot) + idx_n - SP_IDX);
    end
  end
endmodule

// File: rtl/rf_store.sv
module rf_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 30,
  parameter int AW     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     ra_addr_i,
  input  logic [AW-1:0]     rb_addr_i,
  output logic [DATA_W-1:0] ra_data_o,
  output logic [DATA_W-1:0] rb_data_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] mem_d [DEPTH];
  logic [DEPTH-1:0]  row_en;

  for (genvar i = 0; i < DEPTH; i++) begin : g_row
    assign row_en[i] = we_i && (int'(waddr_i) == i);

    always_comb mem_d[i] = wdata_i;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         mem_q[i] <= '0;
      else if (row_en[i]) mem_q[i] <= mem_d[i];
    end
  end

  assign ra_data_o = (int'(ra_addr_i) < DEPTH) ? mem_q[ra_addr_i] : '0;
  assign rb_data_o = (int'(rb_addr_i) < DEPTH) ? mem_q[rb_addr_i] : '0;

  // R6
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && int'(waddr_i) < DEPTH) |=> (mem_q[$past(waddr_i)] == $past(wdata_i)));

  // R6
  idle_read_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> ((ra_addr_i != $past(ra_addr_i)) || $stable(ra_data_o)));
endmodule

// File: rtl/rf_status_bank.sv
module rf_status_bank
  import banked_rf_pkg::*;
#(
  parameter int SR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              we_i,
  input  logic [SR_W-1:0]   wdata_i,
  output logic [SR_W-1:0]   rdata_o
);
  logic [SLOT_W-1:0]           slot;
  logic [EXC_N-1:0][SR_W-1:0]  sr_q;
  logic [EXC_N-1:0][SR_W-1:0]  sr_d;
  logic                        sr_en;

  assign slot  = bank_slot(mode_i);
  assign sr_en = we_i && (slot != SLOT_NONE);

  always_comb begin
    sr_d = sr_q;
    if (sr_en) sr_d[slot - SLOT_W'(1)] = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr_q <= '0;
    else if (sr_en) sr_q <= sr_d;
  end

  assign rdata_o = (slot != SLOT_NONE) ? sr_q[slot - SLOT_W'(1)] : '0;

  // R8
  status_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && (mode_i == MODE_USR || mode_i == MODE_SYS)) |=> $stable(sr_q));

  // R7
  status_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && mode_i == MODE_IRQ) |=> (mode_i != MODE_IRQ || rdata_o == $past(wdata_i)));
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import banked_rf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SR_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        mode_i,
  input  logic [3:0]        ra_idx_i,
  output logic [DATA_W-1:0] ra_data_o,
  input  logic [3:0]        rb_idx_i,
  output logic [DATA_W-1:0] rb_data_o,
  input  logic              we_i,
  input  logic [3:0]        wa_idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] pc_i,
  output logic              branch_valid_o,
  output logic [DATA_W-1:0] branch_target_o,
  input  logic              sr_we_i,
  input  logic [SR_W-1:0]   sr_wdata_i,
  output logic [SR_W-1:0]   sr_rdata_o
);
  localparam int PORTS = 3;  // read A, read B, write

  logic                     rst_sync_n;
  logic [IDX_W-1:0]         port_idx  [PORTS];
  logic [PHYS_AW-1:0]       port_phys [PORTS];
  logic [PORTS-1:0]         port_pc;
  logic                     store_we;
  logic [DATA_W-1:0]        st_a, st_b;

  rf_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign port_idx[0] = ra_idx_i;
  assign port_idx[1] = rb_idx_i;
  assign port_idx[2] = wa_idx_i;

  for (genvar p = 0; p < PORTS; p++) begin : g_map
    rf_bank_map u_map (
      .mode_i   (mode_i),
      .idx_i    (port_idx[p]),
      .phys_o   (port_phys[p]),
      .pc_sel_o (port_pc[p])
    );
  end

  assign store_we        = we_i && !port_pc[2];
  assign branch_valid_o  = we_i && port_pc[2];
  assign branch_target_o = wdata_i;

  rf_store #(
    .DATA_W (DATA_W),
    .DEPTH  (PHYS_N),
    .AW     (PHYS_AW)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .we_i      (store_we),
    .waddr_i   (port_phys[2]),
    .wdata_i   (wdata_i),
    .ra_addr_i (port_phys[0]),
    .rb_addr_i (port_phys[1]),
    .ra_data_o (st_a),
    .rb_data_o (st_b)
  );

  assign ra_data_o = port_pc[0] ? pc_i : st_a;
  assign rb_data_o = port_pc[1] ? pc_i : st_b;

  rf_status_bank #(
    .SR_W (SR_W)
  ) u_status (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .mode_i  (mode_i),
    .we_i    (sr_we_i),
    .wdata_i (sr_wdata_i),
    .rdata_o (sr_rdata_o)
  );

  // R5
  branch_no_store_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    branch_valid_o |-> !store_we);

  // R1
  shared_map_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (int'(wa_idx_i) < SHARED_N) |-> (int'(port_phys[2]) == int'(wa_idx_i)));

  // R2
  fiq_high_map_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode_i == MODE_FIQ && wa_idx_i >= 4'd8 && wa_idx_i <= 4'd12)
      |-> (int'(port_phys[2]) >= FIQ_HI_BASE && int'(port_phys[2]) < BANK_BASE));

  // R3
  user_sys_pair_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode_i == MODE_SYS && wa_idx_i == 4'd13) |-> (int'(port_phys[2]) == BANK_BASE));
endmodule

// File: tb/banked_regfile_tb.sv
module banked_regfile_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  mode;
  logic [3:0]  ra_idx, rb_idx, wa_idx;
  logic [31:0] ra_data, rb_data, wdata, pc, btarget;
  logic        we, bvalid, sr_we;
  logic [31:0] sr_wdata, sr_rdata;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;  // 250 MHz

  banked_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode),
    .ra_idx_i(ra_idx), .ra_data_o(ra_data),
    .rb_idx_i(rb_idx), .rb_data_o(rb_data),
    .we_i(we), .wa_idx_i(wa_idx), .wdata_i(wdata), .pc_i(pc),
    .branch_valid_o(bvalid), .branch_target_o(btarget),
    .sr_we_i(sr_we), .sr_wdata_i(sr_wdata), .sr_rdata_o(sr_rdata)
  );

  // Write order of modes: USR, SYS, SVC, ABT, UND, IRQ, FIQ, unlisted 00
  logic [4:0] mlist [8];
  initial begin
    mlist[0] = 5'h10; mlist[1] = 5'h1F; mlist[2] = 5'h13; mlist[3] = 5'h17;
    mlist[4] = 5'h1B; mlist[5] = 5'h12; mlist[6] = 5'h11; mlist[7] = 5'h00;
  end

  function automatic logic [4:0] grp(input logic [4:0] m);
    if (m == 5'h13 || m == 5'h17 || m == 5'h1B || m == 5'h12 || m == 5'h11) return m;
    return 5'h10;
  endfunction

  function automatic bit shares(input logic [4:0] a, input logic [4:0] b, input int idx);
    if (idx < 8)  return 1'b1;
    if (idx < 13) return (a == 5'h11) == (b == 5'h11);
    return grp(a) == grp(b);
  endfunction

  function automatic logic [31:0] wval(input int k, input int idx);
    return {8'hA0 + 8'(k), 8'(idx), 16'h5A00 + 16'(k * 16 + idx)};
  endfunction

  // Expected word: latest writer sharing the register, or zero
  function automatic logic [31:0] expect_rd(input logic [4:0] m, input int idx, input int nwritten);
    for (int k = nwritten - 1; k >= 0; k--)
      if (shares(mlist[k], m, idx)) return wval(k, idx);
    return 32'h0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sweep_reads(input string req, input int nwritten);
    for (int mi = 0; mi < 8; mi++) begin
      for (int i = 0; i < 16; i++) begin
        @(negedge clk);
        mode = mlist[mi]; ra_idx = 4'(i); rb_idx = 4'(15 - i);
        pc = 32'hC0DE_0000 + 32'(mi * 4);
        #1;
        chk(req, ra_data, (i == 15) ? pc : expect_rd(mlist[mi], i, nwritten));
        chk(req, rb_data, (i == 0) ? pc : expect_rd(mlist[mi], 15 - i, nwritten));
      end
    end
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode = 5'h10; ra_idx = '0; rb_idx = '0; wa_idx = '0;
    we = 1'b0; wdata = '0; pc = '0; sr_we = 1'b0; sr_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9: reset state of registers and status words
    sweep_reads("R9", 0);
    for (int mi = 0; mi < 8; mi++) begin
      @(negedge clk); mode = mlist[mi]; #1;
      chk("R9 status", sr_rdata, 32'h0);
    end

    // R1 R2 R3: write every index in every mode, in list order
    for (int mi = 0; mi < 8; mi++) begin
      for (int i = 0; i < 15; i++) begin
        @(negedge clk);
        mode = mlist[mi]; we = 1'b1; wa_idx = 4'(i); wdata = wval(mi, i);
        #1;
        if (i == 3) chk("R5 no branch", {31'd0, bvalid}, 32'd0);
      end
      @(negedge clk); we = 1'b0;
      // partial check after each mode: R1 R2 R3 with writers so far
      #1;
      for (int i = 0; i < 15; i++) begin
        ra_idx = 4'(i); #1;
        chk("R1/R2/R3 partial", ra_data, expect_rd(mlist[mi], i, mi + 1));
      end
    end
    // R4 on both ports, R1 R2 R3 full mapping
    sweep_reads("R1 R2 R3 R4 mapping", 8);

    // R5: write to index 15 in interrupt mode
    @(negedge clk);
    mode = 5'h12; we = 1'b1; wa_idx = 4'd15; wdata = 32'hB0B0_1234;
    #1;
    chk("R5 branch valid", {31'd0, bvalid}, 32'd1);
    chk("R5 branch target", btarget, 32'hB0B0_1234);
    @(negedge clk); we = 1'b0; #1;
    chk("R5 branch drop", {31'd0, bvalid}, 32'd0);
    for (int i = 0; i < 15; i++) begin
      ra_idx = 4'(i); #1;
      chk("R5 file unchanged", ra_data, expect_rd(5'h12, i, 8));
    end

    // R6: read and write of the same banked register in one cycle
    @(negedge clk);
    mode = 5'h13; ra_idx = 4'd13; rb_idx = 4'd13;
    we = 1'b1; wa_idx = 4'd13; wdata = 32'h7777_0013;
    #1;
    chk("R6 old value A", ra_data, wval(2, 13));
    chk("R6 old value B", rb_data, wval(2, 13));
    @(negedge clk); we = 1'b0; #1;
    chk("R6 new value", ra_data, 32'h7777_0013);
    // other banks untouched by that write
    mode = 5'h17; #1;
    chk("R3 abort pair separate", ra_data, wval(3, 13));

    // R7: one status word per exception mode
    for (int mi = 2; mi < 7; mi++) begin
      @(negedge clk);
      mode = mlist[mi]; sr_we = 1'b1; sr_wdata = 32'h5000_0000 + 32'(mi);
    end
    @(negedge clk); sr_we = 1'b0;
    for (int mi = 0; mi < 8; mi++) begin
      @(negedge clk); mode = mlist[mi]; #1;
      chk("R7/R8 status read", sr_rdata,
          (mi >= 2 && mi < 7) ? 32'h5000_0000 + 32'(mi) : 32'h0);
    end

    // R8: status writes in user, system and unlisted mode are ignored
    for (int mi = 0; mi < 8; mi++) begin
      if (mi < 2 || mi == 7) begin
        @(negedge clk); mode = mlist[mi]; sr_we = 1'b1; sr_wdata = 32'hFFFF_FFFF;
        @(negedge clk); sr_we = 1'b0; #1;
        chk("R8 reads zero", sr_rdata, 32'h0);
      end
    end
    for (int mi = 2; mi < 7; mi++) begin
      @(negedge clk); mode = mlist[mi]; #1;
      chk("R8 exception words intact", sr_rdata, 32'h5000_0000 + 32'(mi));
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule